// File: doc/BRIEF.md
# SPI Burst Byte Sequencer

This block feeds a write-only SPI byte shifter so that a whole group of bytes goes out as one uninterrupted burst. A controller asks for a burst by giving a byte count together with a request pulse. The sequencer then pulls bytes one at a time through a fetch port. The port takes an index and returns a data byte and its data/command bit. The sequencer holds the byte, the bit and a start level for the shifter, and it counts how many bytes it has handed over.

The sequencer is clocked on the rising edge of SCK. The shifter works on the falling edge, so every value crossing between the two has half a cycle to settle. The shifter raises a flag while it drives the next-to-last bit of a byte. When the sequencer sees that flag it places the next byte on its outputs. The shifter then picks that byte up at the byte boundary, and no SCK cycle is lost between bytes. A last-byte flag lets the controller prepare its next command or data group. A one-cycle done pulse follows the release of chip select.

Top module: `spi_burst_seq`

## Requirements
- R1: While reset is held and on the first edge after it, `seq_idle` is 1 and `shf_start`, `last_byte` and `burst_done` are 0, with `fetch_idx` at 0.
- R2: A rising SCK edge in idle that samples `burst_req`=1 with a nonzero `burst_len` drives `shf_start` high. On that edge `shf_byte`/`shf_dc` take the fetched byte for index 0, so the shifter loads it on the next falling edge.
- R3: A request with `burst_len`=0 is ignored: the block stays idle and `shf_start` stays low.
- R4: The count is captured when the burst begins. Changes on `burst_req` or `burst_len` during a burst have no effect, and exactly the captured number of bytes is sent.
- R5: `fetch_idx` starts at 0, rises by one on each byte handed over, and returns to 0 on the done edge. Byte k of the burst is the fetched byte at index k.
- R6: On a rising edge that samples `shf_penult`=1 while bytes remain, the next byte is presented. Successive bytes are therefore loaded by the shifter exactly 8 SCK cycles apart, with no idle cycle between them.
- R7: `shf_start` stays high until the penultimate-bit flag of the final byte. It falls on that edge, so the shifter releases chip select after the final byte.
- R8: `last_byte` rises on the edge that presents the final byte. It is therefore 1 when the shifter loads that byte and 0 at every earlier load, and it falls on the done edge.
- R9: `burst_done` is a one-cycle pulse. It comes on the first rising edge that samples `shf_busy`=0 after the final byte was handed over, with exactly one pulse per burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SCK; all registers update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_req | input | 1 | Request to start a burst (accepted only while idle) |
| burst_len | input | LEN_W | Number of bytes in the burst |
| fetch_idx | output | LEN_W | Index of the byte being fetched |
| fetch_byte | input | DATA_W | Byte at `fetch_idx` |
| fetch_dc | input | 1 | Data/command bit for that byte |
| shf_penult | input | 1 | Shifter is driving the next-to-last bit of a byte |
| shf_busy | input | 1 | Shifter holds chip select active |
| shf_start | output | 1 | Level telling the shifter a byte is ready at a byte boundary |
| shf_byte | output | DATA_W | Byte for the shifter |
| shf_dc | output | 1 | Data/command bit for the shifter |
| last_byte | output | 1 | Final byte of the burst is in flight |
| burst_done | output | 1 | One-cycle pulse after chip-select release |
| seq_idle | output | 1 | Sequencer can accept a burst |

## Verification
Several rules are checked by properties on every edge. The done pulse lasts one cycle and follows a sampled chip-select release. The last-byte flag falls only with done. The fetch index moves only by one or back to zero. The captured count holds steady during a burst. Zero-length requests leave the block idle, and a reload always follows the penultimate flag when bytes remain. Other behaviour needs the bench's model of the falling-edge shifter: the 8-cycle spacing of loads, the exact byte contents, the burst length, and where the last-byte flag sits relative to each load. The bench checks these over several burst lengths up to the largest count.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEND  = 2'd1,
        ST_DRAIN = 2'd2
    } seq_state_e;
endpackage

// File: rtl/spi_burst_cnt.sv
module spi_burst_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (inc)
            cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    // R5: the index never wraps past its top value
    p_cnt_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |-> (cnt_q != '1));
endmodule

// File: rtl/spi_burst_seq.sv
module spi_burst_seq
    import spi_burst_pkg::*;
#(
    parameter int LEN_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_req,
    input  logic [LEN_W-1:0]  burst_len,
    output logic [LEN_W-1:0]  fetch_idx,
    input  logic [DATA_W-1:0] fetch_byte,
    input  logic              fetch_dc,
    input  logic              shf_penult,
    input  logic              shf_busy,
    output logic              shf_start,
    output logic [DATA_W-1:0] shf_byte,
    output logic              shf_dc,
    output logic              last_byte,
    output logic              burst_done,
    output logic              seq_idle
);
    typedef struct packed {
        seq_state_e        state;
        logic [LEN_W-1:0]  len;
        logic [DATA_W-1:0] data;
        logic              dc;
        logic              start;
        logic              last;
        logic              done;
    } seq_regs_t;

    seq_regs_t        d, q;
    logic             cnt_clr, cnt_inc;
    logic [LEN_W-1:0] idx_cnt;
    logic             more_left;

    spi_burst_cnt #(.W(LEN_W)) u_idx (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .inc  (cnt_inc),
        .cnt  (idx_cnt)
    );

    assign more_left = (idx_cnt < q.len);

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (burst_req && (burst_len != '0)) begin
                    d.len   = burst_len;
                    d.data  = fetch_byte;
                    d.dc    = fetch_dc;
                    d.start = 1'b1;
                    d.last  = (burst_len == LEN_W'(1));
                    d.state = ST_SEND;
                    cnt_inc = 1'b1;
                end
            end
            ST_SEND: begin
                if (shf_penult) begin
                    if (more_left) begin
                        d.data  = fetch_byte;
                        d.dc    = fetch_dc;
                        d.last  = ((idx_cnt + LEN_W'(1)) == q.len);
                        cnt_inc = 1'b1;
                    end else begin
                        d.start = 1'b0;
                        d.state = ST_DRAIN;
                    end
                end
            end
            ST_DRAIN: begin
                if (!shf_busy) begin
                    d.state = ST_IDLE;
                    d.done  = 1'b1;
                    d.last  = 1'b0;
                    cnt_clr = 1'b1;
                end
            end
            default: begin
                d.state = ST_IDLE;
                d.start = 1'b0;
                d.last  = 1'b0;
                cnt_clr = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
            q.len   <= '0;
            q.data  <= '0;
            q.dc    <= 1'b0;
            q.start <= 1'b0;
            q.last  <= 1'b0;
            q.done  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign fetch_idx  = idx_cnt;
    assign shf_start  = q.start;
    assign shf_byte   = q.data;
    assign shf_dc     = q.dc;
    assign last_byte  = q.last;
    assign burst_done = q.done;
    assign seq_idle   = (q.state == ST_IDLE);

    // R9: done only after the shifter was seen released
    p_done_after_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |-> !$past(shf_busy));

    // R9: done lasts a single cycle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |=> !burst_done);

    // R8: the last-byte flag drops only together with done
    p_last_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(last_byte) |-> burst_done);

    // R3: a zero-length request leaves the block idle
    p_zero_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_idle && burst_req && (burst_len == '0)) |=> (seq_idle && !shf_start));

    // R5: the fetch index steps by one or returns to zero
    p_idx_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_idx != $past(fetch_idx)) |->
        ((fetch_idx == $past(fetch_idx) + LEN_W'(1)) || (fetch_idx == '0)));

    // R4: the captured count is held for the whole burst
    p_len_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state != ST_IDLE) |=> $stable(q.len));

    // R6: a penultimate flag with bytes left reloads the next byte
    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.state == ST_SEND) && shf_penult && more_left) |=>
        (shf_start && (fetch_idx == $past(fetch_idx) + LEN_W'(1))));
endmodule

// File: tb/spi_burst_seq_tb.sv
module spi_burst_seq_tb;
    localparam int LEN_W  = 8;
    localparam int DATA_W = 8;
    localparam int NVEC   = 6;
    // each entry: {length, seed}
    localparam logic [15:0] VEC [NVEC] = '{
        {8'd1, 8'd3}, {8'd2, 8'd7}, {8'd3, 8'd1},
        {8'd7, 8'd9}, {8'd16, 8'd4}, {8'd255, 8'd2}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              burst_req = 1'b0;
    logic [LEN_W-1:0]  burst_len = '0;
    logic [LEN_W-1:0]  fetch_idx;
    logic [DATA_W-1:0] fetch_byte;
    logic              fetch_dc;
    logic              shf_penult, shf_busy, shf_start, shf_dc;
    logic [DATA_W-1:0] shf_byte;
    logic              last_byte, burst_done, seq_idle;

    logic [DATA_W-1:0] byte_mem [256];
    logic              dc_mem   [256];

    int errors = 0;
    int checks = 0;
    int pclk   = 0;

    // shifter model state and log
    logic       sh_busy;
    int         sh_pos;
    int         rec_n, done_n, rel_t, done_t;
    logic [7:0] rec_byte [512];
    logic       rec_dc   [512];
    logic       rec_last [512];
    int         rec_t    [512];

    always #2.5 clk = ~clk;

    spi_burst_seq #(.LEN_W(LEN_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .burst_req(burst_req), .burst_len(burst_len),
        .fetch_idx(fetch_idx), .fetch_byte(fetch_byte), .fetch_dc(fetch_dc),
        .shf_penult(shf_penult), .shf_busy(shf_busy), .shf_start(shf_start),
        .shf_byte(shf_byte), .shf_dc(shf_dc), .last_byte(last_byte),
        .burst_done(burst_done), .seq_idle(seq_idle)
    );

    always_comb begin
        fetch_byte = byte_mem[fetch_idx];
        fetch_dc   = dc_mem[fetch_idx];
    end

    assign shf_busy   = sh_busy;
    assign shf_penult = sh_busy && (sh_pos == 1);

    always @(posedge clk) pclk <= pclk + 1;

    // falling-edge byte shifter model
    always @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_busy <= 1'b0;
            sh_pos  <= 0;
            rec_n   <= 0;
            done_n  <= 0;
            rel_t   <= 0;
            done_t  <= 0;
        end else begin
            if (!sh_busy || sh_pos == 0) begin
                if (shf_start) begin
                    sh_busy            <= 1'b1;
                    sh_pos             <= 7;
                    rec_byte[rec_n]    <= shf_byte;
                    rec_dc[rec_n]      <= shf_dc;
                    rec_last[rec_n]    <= last_byte;
                    rec_t[rec_n]       <= pclk;
                    rec_n              <= rec_n + 1;
                end else if (sh_busy) begin
                    sh_busy <= 1'b0;
                    rel_t   <= pclk;
                end
            end else begin
                sh_pos <= sh_pos - 1;
            end
            if (burst_done) begin
                done_n <= done_n + 1;
                done_t <= pclk;
            end
        end
    end

    function automatic logic [7:0] exp_byte(int i, int s);
        return 8'((i * 37 + s * 11 + 5) & 255);
    endfunction

    function automatic logic exp_dc(int i, int s);
        return ((i + s) % 3) == 0;
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic fill_mem(input int s);
        for (int i = 0; i < 256; i++) begin
            byte_mem[i] = exp_byte(i, s);
            dc_mem[i]   = exp_dc(i, s);
        end
    endtask

    task automatic wait_done(input int base_done, input int limit);
        for (int k = 0; k < limit; k++) begin
            @(negedge clk);
            if (done_n > base_done) break;
        end
    endtask

    task automatic run_burst(input int len, input int s);
        int base_rec, base_done, t_req, bad_data, bad_gap, bad_last;
        fill_mem(s);
        @(negedge clk);
        base_rec  = rec_n;
        base_done = done_n;
        t_req     = pclk;
        burst_req = 1'b1;
        burst_len = LEN_W'(len);
        @(negedge clk);
        burst_req = 1'b0;
        burst_len = '0;
        wait_done(base_done, len * 8 + 40);
        repeat (3) @(negedge clk);
        check(rec_n - base_rec == len, "R7 byte count", rec_n - base_rec, len);
        check(rec_t[base_rec] == t_req + 1, "R2 first load timing", rec_t[base_rec], t_req + 1);
        bad_data = 0; bad_gap = 0; bad_last = 0;
        for (int i = 0; i < len; i++) begin
            if (rec_byte[base_rec + i] !== exp_byte(i, s) || rec_dc[base_rec + i] !== exp_dc(i, s))
                bad_data++;
            if (i > 0 && rec_t[base_rec + i] - rec_t[base_rec + i - 1] != 8)
                bad_gap++;
            if (rec_last[base_rec + i] !== (i == len - 1))
                bad_last++;
        end
        check(bad_data == 0, "R5 byte order and content", bad_data, 0);
        check(bad_gap == 0, "R6 back-to-back spacing", bad_gap, 0);
        check(bad_last == 0, "R8 last-byte placement", bad_last, 0);
        check(done_n - base_done == 1, "R9 single done pulse", done_n - base_done, 1);
        check(done_t == rel_t + 1, "R9 done after release", done_t, rel_t + 1);
        check(fetch_idx == 0 && seq_idle && !last_byte && !shf_start,
              "R5 index cleared and idle", int'(fetch_idx), 0);
    endtask

    task automatic run_all();
        int base_rec, base_done;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(seq_idle && !shf_start && !last_byte && !burst_done && fetch_idx == 0,
              "R1 outputs in reset", int'(shf_start), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(seq_idle && !shf_start && !last_byte && !burst_done && fetch_idx == 0,
              "R1 outputs after reset", int'(shf_start), 0);

        for (int v = 0; v < NVEC; v++)
            run_burst(int'(VEC[v][15:8]), int'(VEC[v][7:0]));

        // R3: zero-length request ignored
        base_rec = rec_n;
        @(negedge clk);
        burst_req = 1'b1;
        burst_len = '0;
        repeat (2) @(negedge clk);
        burst_req = 1'b0;
        repeat (20) @(negedge clk);
        check(rec_n == base_rec && seq_idle && !shf_start, "R3 zero length ignored",
              rec_n - base_rec, 0);

        // R4: requests and count changes during a burst ignored
        fill_mem(5);
        base_rec  = rec_n;
        base_done = done_n;
        @(negedge clk);
        burst_req = 1'b1;
        burst_len = 8'd4;
        @(negedge clk);
        burst_len = 8'd9;
        repeat (12) @(negedge clk);
        burst_req = 1'b0;
        burst_len = '0;
        wait_done(base_done, 80);
        repeat (3) @(negedge clk);
        check(rec_n - base_rec == 4, "R4 captured count", rec_n - base_rec, 4);
        check(done_n - base_done == 1, "R4 one burst only", done_n - base_done, 1);

        // R2: a new burst is accepted right after the previous one
        run_burst(2, 6);
    endtask

    initial begin
        fill_mem(0);
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule